// File: doc/BRIEF.md
# EEPROM Page-Write Load Controller

This block is the device-side control logic of a byte-wide parallel EEPROM. It watches three active-low strobes: chip select, output enable and write strobe. These are already synchronized to a free-running clock. The block decodes them into read, byte-load and inhibit conditions. A byte load stores the address at the moment the load condition becomes true. It keeps the data that was present in the last clock cycle the condition held. Because of this, a cycle closed by either chip select or write strobe behaves the same way.

Loaded bytes collect in a page buffer with one entry per byte offset. Every load of one operation must target the same page. A load aimed at another page raises an error flag and is dropped. When no new load begins within a timeout window, a timed programming phase starts. While it runs, the busy output is high and reads return a status byte. When it ends, every buffered byte is copied into the storage array, which is modelled as a register array. A digital low-supply input blocks every read and every load.

Top module: `eeprom_page_loader`

## Requirements
- R1: `dout_en` is 1 exactly while `ce_n`=0, `oe_n`=0 and `supply_low`=0. Outside programming, `dout` then shows the stored byte at `addr`, and every location reads 0 after reset.
- R2: A load takes its address in the first cycle where `ce_n`=0, `we_n`=0, `oe_n`=1 and the block is idle, which is the later of the two strobe falls. Changes to `addr` later in the same load are ignored.
- R3: A load's data is the value of `din` in the last cycle the load condition held, which is the earlier of the two strobe rises. A load closed by chip select stores data just as one closed by write strobe does.
- R4: The low OFF_W address bits select one of 2^OFF_W buffer entries. A later load to the same offset overwrites the earlier byte. Only the loaded offsets of the page are changed by programming.
- R5: Programming starts once LOAD_TIMEOUT cycles have passed since the last load start with no new load. It never starts while a load is in progress, and it never starts when no byte was accepted.
- R6: With `oe_n`=0, `we_n`=1 or `ce_n`=1, no load takes place and no byte is stored.
- R7: A load condition that lasts fewer than MIN_PULSE cycles stores nothing.
- R8: While `supply_low`=1, `dout_en` stays 0 and no load is accepted.
- R9: `busy` is high for exactly PROG_CYCLES cycles, and the array is updated when it falls. Strobe activity while `busy`=1 stores nothing.
- R10: A load whose upper address bits (the page field) differ from the first accepted load's page field is not stored. It sets `page_err`, which stays set until programming starts.
- R11: A read while `busy`=1 returns the last accepted byte with its bit DATA_W-1 inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low, synchronized |
| oe_n | input | 1 | Output enable, active low, synchronized |
| we_n | input | 1 | Write strobe, active low, synchronized |
| supply_low | input | 1 | High when the supply is at or below its safe level |
| addr | input | ADDR_W | Byte address; the upper bits are the page field |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data or status byte |
| dout_en | output | 1 | Tristate enable for the data bus drivers |
| busy | output | 1 | Programming phase in progress |
| page_err | output | 1 | A load targeted a different page |

## Verification
The assertions assume that the strobes arrive already synchronized, so each is a clean level for whole clock cycles. They also assume that the page buffer is never cleared while a load is open, which the programming phase guarantees by locking out loads. The bench changes strobes, address and data only on the falling clock edge. It keeps the gap between loads of one page well inside the timeout, and it leaves the timeout window plus the programming time before it reads back. Runt pulses, inhibited strobe combinations and low-supply periods are applied on purpose, each on its own and with enough idle time afterwards to show that no programming followed.

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader #(
  parameter int ADDR_W       = 10,
  parameter int OFF_W        = 8,
  parameter int DATA_W       = 8,
  parameter int LOAD_TIMEOUT = 20000,
  parameter int MIN_PULSE    = 2,
  parameter int PROG_CYCLES  = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              supply_low,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy,
  output logic              page_err
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PAGE_LEN = 1 << OFF_W;
  localparam int PG_W     = ADDR_W - OFF_W;
  localparam int TW       = $clog2(LOAD_TIMEOUT + 1);
  localparam int PW       = $clog2(MIN_PULSE + 1);
  localparam int CW       = $clog2(PROG_CYCLES + 1);

  logic [DATA_W-1:0] mem   [DEPTH];
  logic [DATA_W-1:0] pbuf  [PAGE_LEN];
  logic [PAGE_LEN-1:0] vld;
  logic              active, page_open;
  logic [ADDR_W-1:0] a_lat;
  logic [DATA_W-1:0] d_hold, last_q;
  logic [PG_W-1:0]   page_q;
  logic [TW-1:0]     tmr;
  logic [PW-1:0]     pw;
  logic [CW-1:0]     pcnt;

  wire              wcond     = ~ce_n & ~we_n & oe_n & ~supply_low & ~busy;
  wire              start     = ~active & wcond;
  wire [PG_W-1:0]   lat_pg    = a_lat[ADDR_W-1:OFF_W];
  wire [OFF_W-1:0]  lat_off   = a_lat[OFF_W-1:0];
  wire              commit    = active & ~wcond & ~supply_low & (pw >= PW'(MIN_PULSE));
  wire              pg_ok     = ~page_open | (lat_pg == page_q);
  wire              expire    = page_open & ~active & ~wcond & (tmr >= TW'(LOAD_TIMEOUT));
  wire              prog_done = busy & (pcnt == CW'(PROG_CYCLES - 1));

  assign dout_en = ~ce_n & ~oe_n & ~supply_low;
  assign dout    = busy ? {~last_q[DATA_W-1], last_q[DATA_W-2:0]} : mem[addr];

  // strobe decode: address at load start, data tracked while the load holds
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      a_lat  <= '0;
      d_hold <= '0;
      pw     <= '0;
    end else if (start) begin
      active <= 1'b1;
      a_lat  <= addr;
      d_hold <= din;
      pw     <= PW'(1);
    end else if (active && wcond) begin
      d_hold <= din;
      if (pw < PW'(MIN_PULSE)) pw <= pw + PW'(1);
    end else if (active) begin
      active <= 1'b0;
    end
  end

  // page collection and byte-load window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_open <= 1'b0;
      page_q    <= '0;
      vld       <= '0;
      last_q    <= '0;
      page_err  <= 1'b0;
      tmr       <= '0;
    end else begin
      if (start) tmr <= '0;
      else if (page_open && tmr < TW'(LOAD_TIMEOUT)) tmr <= tmr + TW'(1);
      if (expire) begin
        page_open <= 1'b0;
        page_err  <= 1'b0;
      end
      if (prog_done) vld <= '0;
      if (commit) begin
        if (pg_ok) begin
          vld[lat_off] <= 1'b1;
          page_open    <= 1'b1;
          page_q       <= lat_pg;
          last_q       <= d_hold;
        end else begin
          page_err <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit && pg_ok) pbuf[lat_off] <= d_hold;
  end

  // timed programming phase
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pcnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (busy) begin
      if (prog_done) begin
        busy <= 1'b0;
        pcnt <= '0;
        for (int i = 0; i < PAGE_LEN; i++)
          if (vld[i]) mem[{page_q, OFF_W'(i)}] <= pbuf[i];
      end else begin
        pcnt <= pcnt + CW'(1);
      end
    end else if (expire) begin
      busy <= 1'b1;
    end
  end

  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) |-> $stable(a_lat));
  a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    page_open && $past(page_open) |-> $stable(page_q));
  a_r5_prog_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(page_open) && !$past(active));
  a_r7_runt_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) && ($past(pw) < PW'(MIN_PULSE)) |-> $stable(vld) && !$rose(page_err));
  a_r9_no_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !active);
  a_r10_err_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_err) |-> $stable(vld));
endmodule

// File: tb/eeprom_page_loader_bench.sv
`timescale 1ns/1ps
module eeprom_page_loader_bench;
  localparam int ADDR_W = 10, OFF_W = 8, DATA_W = 8;
  localparam int TMO = 20, MINP = 2, PROG = 30;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, supply_low = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic dout_en, busy, page_err;
  int checks = 0, errors = 0, bc = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) if (busy) bc++;

  eeprom_page_loader #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
    .LOAD_TIMEOUT(TMO), .MIN_PULSE(MINP), .PROG_CYCLES(PROG)) u_eeprom_page_loader (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .supply_low(supply_low), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .busy(busy), .page_err(page_err));

  // addr[25:16], write data [15:8], expected read-back [7:0]
  localparam logic [25:0] VEC [8] = '{
    {10'h100, 8'h11, 8'h11}, {10'h105, 8'h22, 8'h99},
    {10'h1FF, 8'hFE, 8'hFE}, {10'h180, 8'h80, 8'h80},
    {10'h101, 8'h01, 8'h01}, {10'h105, 8'h99, 8'h99},
    {10'h17F, 8'h7F, 8'h7F}, {10'h1AA, 8'h55, 8'h55}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                      input int len, input bit by_ce);
    @(negedge clk); addr = a; din = d; oe_n = 1;
    if (by_ce) we_n = 0; else ce_n = 0;
    @(negedge clk);
    if (by_ce) ce_n = 0; else we_n = 0;
    repeat (len) @(negedge clk);
    if (by_ce) ce_n = 1; else we_n = 1;
    @(negedge clk); ce_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d, output logic en);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    #1; d = dout; en = dout_en;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_prog();
    int n = 0;
    while (!busy && n < 100) begin @(negedge clk); n++; end
    while (busy && n < 200) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d;
    logic en;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 busy after reset", busy, 0);
    check("R10 page_err after reset", page_err, 0);
    check("R1 bus released after reset", dout_en, 0);
    rd(10'h000, d, en);
    check("R1 read enable", en, 1);
    check("R1 reset content", d, 0);

    // R4 table of loads into one page, both strobe orders
    for (int i = 0; i < 8; i++) load(VEC[i][25:16], VEC[i][15:8], 3, i[0]);
    wait_prog();
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][25:16], d, en);
      check("R4 page read-back", d, VEC[i][7:0]);
    end
    rd(10'h102, d, en);
    check("R4 unloaded offset untouched", d, 0);
    rd(10'h005, d, en);
    check("R4 other page untouched", d, 0);

    // R5 timeout, R11 status, R9 lockout and length
    bc = 0;
    load(10'h210, 8'h3C, 3, 0);
    repeat (5) @(negedge clk);
    check("R5 no early programming", busy, 0);
    n = 5;
    while (!busy && n < 60) begin @(negedge clk); n++; end
    check("R5 programming started", busy, 1);
    check("R5 start inside window", int'(n >= 10 && n <= 25), 1);
    rd(10'h000, d, en);
    check("R11 status byte", d, 8'hBC);
    load(10'h211, 8'h77, 3, 0);
    n = 0;
    while (busy && n < 100) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    check("R9 busy length", bc, PROG);
    bc = 0;
    repeat (40) @(negedge clk);
    check("R9 load during busy opened no page", bc, 0);
    rd(10'h211, d, en);
    check("R9 load during busy ignored", d, 0);
    rd(10'h210, d, en);
    check("R9 array updated", d, 8'h3C);

    // R2 address change and R3 data change inside one load, then a CE-closed load
    @(negedge clk); addr = 10'h220; din = 8'hA1; ce_n = 0;
    @(negedge clk); we_n = 0;
    @(negedge clk); addr = 10'h230; din = 8'hA2;
    @(negedge clk); din = 8'hB3;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
    load(10'h221, 8'hC4, 2, 1);
    wait_prog();
    rd(10'h220, d, en);
    check("R2 R3 first address, last data", d, 8'hB3);
    rd(10'h230, d, en);
    check("R2 later address ignored", d, 0);
    rd(10'h221, d, en);
    check("R3 chip-select closed load", d, 8'hC4);

    // R6 inhibits
    bc = 0;
    @(negedge clk); addr = 10'h340; din = 8'hEE; ce_n = 0; oe_n = 0; we_n = 0;
    repeat (4) @(negedge clk);
    ce_n = 1; oe_n = 1; we_n = 1;
    @(negedge clk); ce_n = 1; we_n = 0;
    repeat (4) @(negedge clk);
    we_n = 1;
    @(negedge clk); ce_n = 0;
    repeat (4) @(negedge clk);
    ce_n = 1;
    repeat (40) @(negedge clk);
    check("R6 no programming after inhibited strobes", bc, 0);
    rd(10'h340, d, en);
    check("R6 inhibited load not stored", d, 0);

    // R7 runt pulse
    bc = 0;
    load(10'h350, 8'h5E, 1, 0);
    repeat (40) @(negedge clk);
    check("R7 runt opened no page", bc, 0);
    rd(10'h350, d, en);
    check("R7 runt not stored", d, 0);

    // R8 low supply
    supply_low = 1;
    rd(10'h210, d, en);
    check("R8 bus disabled on low supply", en, 0);
    bc = 0;
    load(10'h360, 8'h42, 3, 0);
    repeat (40) @(negedge clk);
    check("R8 no programming on low supply", bc, 0);
    supply_low = 0;
    rd(10'h360, d, en);
    check("R8 load on low supply dropped", d, 0);
    @(negedge clk); ce_n = 0; oe_n = 1; #1;
    check("R1 bus off with output enable high", dout_en, 0);
    @(negedge clk); ce_n = 1;

    // R10 page mismatch
    load(10'h301, 8'h5A, 3, 0);
    load(10'h001, 8'hA5, 3, 0);
    check("R10 mismatch flagged", page_err, 1);
    wait_prog();
    check("R10 flag cleared by programming", page_err, 0);
    rd(10'h301, d, en);
    check("R10 first page written", d, 8'h5A);
    rd(10'h001, d, en);
    check("R10 mismatched byte dropped", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule